// File: doc/BRIEF.md
# Addressable Tap Shift Register

A serial delay line of up to 32 one-bit stages. Each enabled clock edge moves every stage one place along and loads a new bit at the head. A run-time stage index picks which stage appears on a combinational tap output, so the delay from input to tap is the index plus one. A second output always carries the final stage and ignores the index. That output feeds the serial input of the next instance when a longer delay line is chained.

A mode input splits the array into two independent 16-stage lines. They share the clock and the shift enable, and each has its own serial input and its own tap. Holding the index at a constant gives a fixed-length delay. A build-time option places a flip-flop after each tap. This adds one cycle of latency and shortens the timing path. Stage contents have no reset. Only the optional tap flip-flops clear on the synchronous reset.

Top module: `addr_tap_shifter`

## Requirements
- R1: With `split_mode`=0 and `OUT_REG`=0, `tap_lo` equals stage `sel_lo` (0..31), so a bit on `sin_lo` reaches `tap_lo` after `sel_lo`+1 enabled edges.
- R2: A change of `sel_lo` or `sel_hi` updates the taps with no clock edge.
- R3: `chain_out` always equals the last stage (index 31), whatever the tap indices are.
- R4: On an edge where `shift_en`=0, no stage changes, so the taps and `chain_out` keep their values for unchanged indices.
- R5: A constant `sel_lo` of 6 gives a delay of exactly 7 enabled edges from `sin_lo` to `tap_lo`.
- R6: With `split_mode`=1, stage 0 loads from `sin_lo` and stage 16 loads from `sin_hi`. Bit 4 of `sel_lo` is ignored, and `tap_lo` reads stage `sel_lo[3:0]`. `chain_out` gives `sin_hi` delayed by 16 enabled edges.
- R7: `tap_hi` reads stage 16+`sel_hi` in both modes. With `split_mode`=0, stage 16 loads from stage 15, so `tap_hi` delays `sin_lo` by 17+`sel_hi` edges.
- R8: With `OUT_REG`=1, each tap is registered on every clock edge. Each tap then shows, one edge later, the value the unregistered tap had before that edge. A synchronous `rst`=1 clears both taps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (tap flip-flops only) |
| shift_en | input | 1 | Shift enable |
| split_mode | input | 1 | 0: one 32-stage line, 1: two 16-stage lines |
| sin_lo | input | 1 | Serial input to stage 0 |
| sin_hi | input | 1 | Serial input to stage 16 in split mode |
| sel_lo | input | 5 | Tap index for the low tap |
| sel_hi | input | 4 | Tap index within the upper half |
| tap_lo | output | 1 | Low tap output |
| tap_hi | output | 1 | Upper-half tap output |
| chain_out | output | 1 | Last stage, for chaining |

## Verification
The interesting collision is a tap index change in the same cycle as a shift. The tap must show the newly selected stage of the pre-edge contents before the edge. After the edge it must show the same index over the shifted contents. Random stimulus changes the indices, the enable and the serial bits every cycle. The bench samples each tap after the inputs settle, before the edge, and compares it against a bench model of the stage array. A second instance with the output register is checked against the model value from the previous edge, so the one-cycle offset is judged explicitly.

// File: rtl/tapsr_pkg.sv
package tapsr_pkg;

    localparam int DEF_DEPTH = 32;

    typedef enum logic {
        MODE_UNIFIED = 1'b0,
        MODE_SPLIT   = 1'b1
    } mode_e;

    typedef struct packed {
        logic lo;
        logic hi;
    } tap_pair_t;

    // number of index bits for a given depth (depth is a power of two)
    function automatic int idx_bits(input int depth);
        return $clog2(depth);
    endfunction

endpackage

// File: rtl/tapsr_stages.sv
module tapsr_stages
    import tapsr_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  mode_e            mode,
    input  logic             sin_lo,
    input  logic             sin_hi,
    output logic [DEPTH-1:0] stages
);
    localparam int HALF = DEPTH / 2;

    logic [DEPTH-1:0] nxt;

    // each stage takes its predecessor; the head of the upper half
    // switches source with the mode
    always_comb begin
        nxt[0] = sin_lo;
        for (int i = 1; i < DEPTH; i++) begin
            nxt[i] = stages[i-1];
        end
        if (mode == MODE_SPLIT) begin
            nxt[HALF] = sin_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (shift_en) begin
            stages <= nxt;
        end
    end

    a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(stages));

    a_r1_head_loads_input: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> stages[0] == $past(sin_lo));

    a_r1_stage_advance: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> stages[DEPTH-1] == $past(stages[DEPTH-2]));

    a_r6_upper_head_split: assert property (@(posedge clk) disable iff (rst)
        (shift_en && mode == MODE_SPLIT) |=> stages[HALF] == $past(sin_hi));

    a_r7_halves_joined: assert property (@(posedge clk) disable iff (rst)
        (shift_en && mode == MODE_UNIFIED) |=> stages[HALF] == $past(stages[HALF-1]));

endmodule

// File: rtl/tapsr_select.sv
module tapsr_select
    import tapsr_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int AW    = idx_bits(DEPTH)
) (
    input  logic [DEPTH-1:0] stages,
    input  mode_e            mode,
    input  logic [AW-1:0]    sel_lo,
    input  logic [AW-2:0]    sel_hi,
    output tap_pair_t        taps
);
    logic [AW-1:0] idx_lo;
    logic [AW-1:0] idx_hi;

    always_comb begin
        // in split mode the top index bit is dropped so the low tap
        // stays inside the lower half
        idx_lo = (mode == MODE_SPLIT) ? {1'b0, sel_lo[AW-2:0]} : sel_lo;
        idx_hi = {1'b1, sel_hi};
        taps.lo = stages[idx_lo];
        taps.hi = stages[idx_hi];
    end

endmodule

// File: rtl/tapsr_outreg.sv
module tapsr_outreg
    import tapsr_pkg::*;
#(
    parameter bit ENABLE = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  tap_pair_t d,
    output tap_pair_t q
);
    generate
        if (ENABLE) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else begin
                    q <= d;
                end
            end

            a_r8_reset_clears: assert property (@(posedge clk)
                rst |=> q == '0);

            a_r8_one_cycle_late: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> q == $past(d));
        end else begin : g_pass
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/addr_tap_shifter.sv
module addr_tap_shifter
    import tapsr_pkg::*;
#(
    parameter int DEPTH   = DEF_DEPTH,
    parameter bit OUT_REG = 1'b0,
    parameter int AW      = idx_bits(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_en,
    input  logic          split_mode,
    input  logic          sin_lo,
    input  logic          sin_hi,
    input  logic [AW-1:0] sel_lo,
    input  logic [AW-2:0] sel_hi,
    output logic          tap_lo,
    output logic          tap_hi,
    output logic          chain_out
);
    mode_e            mode;
    logic [DEPTH-1:0] stages;
    tap_pair_t        taps_c;
    tap_pair_t        taps_q;

    assign mode = mode_e'(split_mode);

    tapsr_stages #(.DEPTH(DEPTH)) u_stages (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .mode     (mode),
        .sin_lo   (sin_lo),
        .sin_hi   (sin_hi),
        .stages   (stages)
    );

    tapsr_select #(.DEPTH(DEPTH), .AW(AW)) u_select (
        .stages (stages),
        .mode   (mode),
        .sel_lo (sel_lo),
        .sel_hi (sel_hi),
        .taps   (taps_c)
    );

    tapsr_outreg #(.ENABLE(OUT_REG)) u_outreg (
        .clk (clk),
        .rst (rst),
        .d   (taps_c),
        .q   (taps_q)
    );

    assign tap_lo    = taps_q.lo;
    assign tap_hi    = taps_q.hi;
    assign chain_out = stages[DEPTH-1];

    a_r3_chain_follows_tail: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> chain_out == $past(stages[DEPTH-2]));

endmodule

// File: tb/addr_tap_shifter_test.sv
`timescale 1ns/10ps
module addr_tap_shifter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       shift_en = 1'b0;
    logic       split_mode = 1'b0;
    logic       sin_lo = 1'b0;
    logic       sin_hi = 1'b0;
    logic [4:0] sel_lo = '0;
    logic [3:0] sel_hi = '0;
    logic       tap_lo, tap_hi, chain_out;
    logic       rtap_lo, rtap_hi, rchain_out;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] mdl = '0;
    logic        exp_rlo = 1'b0;
    logic        exp_rhi = 1'b0;
    bit          armed = 1'b0;

    always #2 clk = ~clk;

    addr_tap_shifter #(.OUT_REG(1'b0)) uut (
        .clk(clk), .rst(rst), .shift_en(shift_en), .split_mode(split_mode),
        .sin_lo(sin_lo), .sin_hi(sin_hi), .sel_lo(sel_lo), .sel_hi(sel_hi),
        .tap_lo(tap_lo), .tap_hi(tap_hi), .chain_out(chain_out)
    );

    addr_tap_shifter #(.OUT_REG(1'b1)) uut_reg (
        .clk(clk), .rst(rst), .shift_en(shift_en), .split_mode(split_mode),
        .sin_lo(sin_lo), .sin_hi(sin_hi), .sel_lo(sel_lo), .sel_hi(sel_hi),
        .tap_lo(rtap_lo), .tap_hi(rtap_hi), .chain_out(rchain_out)
    );

    function automatic logic ref_lo(input logic [31:0] m, input logic sp, input logic [4:0] a);
        return sp ? m[{1'b0, a[3:0]}] : m[a];
    endfunction

    function automatic logic ref_hi(input logic [31:0] m, input logic [3:0] a);
        return m[{1'b1, a}];
    endfunction

    function automatic logic [31:0] ref_shift(input logic [31:0] m, input logic sp,
                                              input logic a, input logic b);
        logic [31:0] n;
        n = {m[30:0], a};
        if (sp) n[16] = b;
        return n;
    endfunction

    task automatic chk(input string req, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b (t=%0t)", req, got, exp, $time);
        end
    endtask

    task automatic compare_now();
        string rq;
        rq = !shift_en ? "R4" : (split_mode ? "R6" : "R1");
        chk(rq, tap_lo, ref_lo(mdl, split_mode, sel_lo));
        chk(split_mode ? "R6" : "R7", tap_hi, ref_hi(mdl, sel_hi));
        chk("R3", chain_out, mdl[31]);
        chk("R8", rtap_lo, exp_rlo);
        chk("R8", rtap_hi, exp_rhi);
    endtask

    // drive at the falling edge, compare before the rising edge, then
    // advance the model across the rising edge
    task automatic step(input logic en, input logic sp, input logic a, input logic b,
                        input logic [4:0] sl, input logic [3:0] sh);
        @(negedge clk);
        shift_en = en; split_mode = sp; sin_lo = a; sin_hi = b;
        sel_lo = sl; sel_hi = sh;
        #1;
        if (armed) compare_now();
        @(posedge clk);
        exp_rlo = ref_lo(mdl, sp, sl);
        exp_rhi = ref_hi(mdl, sh);
        if (en) mdl = ref_shift(mdl, sp, a, b);
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: got hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed;
        int pos;
        logic sp;
        seed = 32'h5eed_0a17;
        void'($urandom(seed));

        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8", rtap_lo, 1'b0);   // R8 reset clears registered taps
        chk("R8", rtap_hi, 1'b0);
        rst = 1'b0;

        // fill the array so the model is fully known
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'($urandom), 1'b0, 5'd0, 4'd0);
        armed = 1'b1;

        // R2: index sweep with no clock edge between changes
        @(negedge clk);
        shift_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            sel_lo = 5'(i * 4 + 1);
            sel_hi = 4'(i * 2);
            #0.2;
            chk("R2", tap_lo, ref_lo(mdl, 1'b0, sel_lo));
            chk("R2", tap_hi, ref_hi(mdl, sel_hi));
        end
        @(posedge clk);
        exp_rlo = ref_lo(mdl, 1'b0, sel_lo);
        exp_rhi = ref_hi(mdl, sel_hi);

        // R5: fixed index 6 gives a delay of 7
        for (int i = 0; i < 35; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 5'd6, 4'd0);
        step(1'b1, 1'b0, 1'b1, 1'b0, 5'd6, 4'd0);
        pos = 0;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            shift_en = 1'b1; sin_lo = 1'b0;
            #1;
            if (tap_lo && pos == 0) pos = i;
            @(posedge clk);
            exp_rlo = ref_lo(mdl, 1'b0, 5'd6);
            exp_rhi = ref_hi(mdl, 4'd0);
            mdl = ref_shift(mdl, 1'b0, 1'b0, 1'b0);
        end
        n_cmp++;
        if (pos != 7) begin
            n_bad++;
            $display("FAIL R5: got delay %0d expected 7", pos);
        end

        // R6: index bit 4 ignored in split mode
        step(1'b1, 1'b1, 1'b1, 1'b0, 5'd0, 4'd0);
        @(negedge clk);
        shift_en = 1'b0; sel_lo = 5'd16;
        #1;
        chk("R6", tap_lo, 1'b1);
        @(posedge clk);
        exp_rlo = ref_lo(mdl, 1'b1, 5'd16);
        exp_rhi = ref_hi(mdl, sel_hi);

        // R6: chain_out is sin_hi delayed by 16 in split mode
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 5'd3, 4'd5);
        step(1'b1, 1'b1, 1'b0, 1'b1, 5'd3, 4'd5);
        for (int i = 1; i < 16; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 5'd3, 4'd5);
        @(negedge clk);
        shift_en = 1'b0;
        #1;
        chk("R6", chain_out, 1'b1);
        @(posedge clk);
        exp_rlo = ref_lo(mdl, 1'b1, 5'd3);
        exp_rhi = ref_hi(mdl, 4'd5);

        // random mix: enable, indices, data and mode all change
        sp = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) sp = ~sp;
            step(($urandom % 4) != 0, sp, 1'($urandom), 1'($urandom),
                 5'($urandom), 4'($urandom));
        end

        // R8: reset mid-run clears registered taps
        @(negedge clk);
        rst = 1'b1; shift_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R8", rtap_lo, 1'b0);
        chk("R8", rtap_hi, 1'b0);
        rst = 1'b0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule